// File: doc/BRIEF.md
# Supply Switchover and Trickle-Charge Controller

This block decides every clock cycle whether the device should run from the main supply or from the backup source. It also drives the enables of three trickle-charge switches. The supply voltages arrive as unsigned digital codes: main supply, backup, and a fixed power-fail reference. The switchover threshold is the smaller of the reference code and the backup code. When the main-supply code drops below that threshold, the block raises `on_backup` on the next clock edge. When the main-supply code is back at or above the threshold, it clears `on_backup` on the next edge.

Charging is guarded twice, so that no single corrupted write can start it. A 4-bit key in the guard register (address 09h) must hold exactly 5h to close the key switch. A separate enable bit in the path register (address 08h) closes the second switch. The diode-bypass switch closes only when its own bit is set and both charge switches are already closed. Entering backup opens every switch and returns all charge fields to their reset values, so software must program them again after power returns. While the block is on backup it ignores writes.

The write port is a plain register strobe. The block accepts a write in the cycle its strobe is high and never exerts back-pressure. No data stream crosses the block, so there is no valid/ready pairing.

Top module: `sup_backup_ctl`

## Requirements
- R1: When `vbak_code` > `vref_code`, `on_backup` is 1 in the cycle after a cycle with `vmain_code` < `vref_code`. A `vmain_code` equal to `vref_code` keeps the block on main.
- R2: When `vbak_code` < `vref_code`, the threshold is `vbak_code`. The block stays on main while `vmain_code` >= `vbak_code`, even if `vmain_code` is below the reference. It moves to backup one cycle after `vmain_code` < `vbak_code`.
- R3: The block returns to main (`on_backup` = 0) one cycle after a cycle where `vmain_code` is at or above the threshold.
- R4: `sw_key_closed` is 1 only while on main and only when guard register 09h bits [3:0] hold 5h. Any other key value opens it.
- R5: `sw_path_closed` is 1 only while on main with path register 08h bit [5] = 1. Other bits of that register have no effect on it.
- R6: `sw_bypass_closed` is 1 only when guard register 09h bit [6] = 1 and both `sw_key_closed` and `sw_path_closed` are 1.
- R7: All three switch outputs are 0 in the first backup cycle. All charge fields are then at their defaults, so after returning to main the outputs stay 0 until software writes the fields again. A write on the edge of entry is discarded.
- R8: Writes made while `on_backup` = 1 have no effect.
- R9: After reset, `on_backup` is 0 and the key is 0h, the path bit is 0 and the bypass bit is 0. All switches are therefore open.
- R10: Writes to addresses other than 08h and 09h leave all switch outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vmain_code | input | CODE_W | Main supply level code |
| vbak_code | input | CODE_W | Backup level code |
| vref_code | input | CODE_W | Power-fail reference code |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| on_backup | output | 1 | High while running from backup |
| sw_key_closed | output | 1 | Keyed charge switch enable |
| sw_path_closed | output | 1 | Second charge switch enable |
| sw_bypass_closed | output | 1 | Diode-bypass switch enable |

## Verification
The hardest case is a register write that lands on the same clock edge as the drop into backup. Entry must win, so the write is lost. The stimulus fully programs the charge fields first. It then lowers the main-supply code in the same cycle that it writes a valid key. Next it raises the supply again with no write, which shows that the fields were cleared. The threshold selection is exercised at its equality points with both orderings of the backup and reference codes. This includes a main-supply code that is below the reference but still above a lower backup code.

// File: rtl/sup_pkg.sv
package sup_pkg;
  parameter int CODE_W = 8;
  parameter int ADDR_W = 8;
  parameter int DATA_W = 8;
  parameter int KEY_W  = 4;

  localparam logic [ADDR_W-1:0] ADDR_PATH  = 8'h08;
  localparam logic [ADDR_W-1:0] ADDR_GUARD = 8'h09;
  localparam int PATH_BIT   = 5;
  localparam int BYPASS_BIT = 6;
  localparam logic [KEY_W-1:0] KEY_OPEN  = 4'h5;
  localparam logic [KEY_W-1:0] KEY_RESET = 4'h0;

  typedef struct packed {
    logic [KEY_W-1:0] key;
    logic             path_en;
    logic             bypass_en;
  } chg_fields_t;

  localparam chg_fields_t FIELDS_RESET = '{key: KEY_RESET, path_en: 1'b0, bypass_en: 1'b0};
endpackage

// File: rtl/sup_threshold_cmp.sv
module sup_threshold_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] vmain,
  input  logic [W-1:0] vbak,
  input  logic [W-1:0] vref,
  output logic         below
);
  logic [W-1:0] thr;

  always_comb begin
    thr   = (vbak < vref) ? vbak : vref;
    below = (vmain < thr);
  end
endmodule

// File: rtl/sup_mode_reg.sv
module sup_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic below,
  output logic on_backup,
  output logic entering
);
  always_ff @(posedge clk) begin
    if (!rst_n) on_backup <= 1'b0;
    else        on_backup <= below;
  end

  assign entering = below & ~on_backup;
endmodule

// File: rtl/chg_field_regs.sv
module chg_field_regs
  import sup_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          block_wr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output chg_fields_t   fields
);
  logic hit_guard, hit_path;

  assign hit_guard = wr_en && !block_wr && (wr_addr == ADDR_GUARD);
  assign hit_path  = wr_en && !block_wr && (wr_addr == ADDR_PATH);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      fields <= FIELDS_RESET;
    end else begin
      if (hit_guard) begin
        fields.key       <= wr_data[KEY_W-1:0];
        fields.bypass_en <= wr_data[BYPASS_BIT];
      end
      if (hit_path) fields.path_en <= wr_data[PATH_BIT];
    end
  end
endmodule

// File: rtl/chg_switch_drv.sv
module chg_switch_drv
  import sup_pkg::*;
(
  input  chg_fields_t fields,
  input  logic        on_backup,
  output logic        key_closed,
  output logic        path_closed,
  output logic        bypass_closed
);
  always_comb begin
    key_closed    = !on_backup && (fields.key == KEY_OPEN);
    path_closed   = !on_backup && fields.path_en;
    bypass_closed = key_closed && path_closed && fields.bypass_en;
  end
endmodule

// File: rtl/sup_backup_ctl.sv
module sup_backup_ctl
  import sup_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] vmain_code,
  input  logic [CW-1:0] vbak_code,
  input  logic [CW-1:0] vref_code,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          on_backup,
  output logic          sw_key_closed,
  output logic          sw_path_closed,
  output logic          sw_bypass_closed
);
  logic        below, entering;
  chg_fields_t fields;

  sup_threshold_cmp #(.W(CW)) u_cmp (
    .vmain(vmain_code), .vbak(vbak_code), .vref(vref_code), .below(below)
  );

  sup_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .below(below),
    .on_backup(on_backup), .entering(entering)
  );

  chg_field_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .clear(entering), .block_wr(on_backup),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .fields(fields)
  );

  chg_switch_drv u_drv (
    .fields(fields), .on_backup(on_backup),
    .key_closed(sw_key_closed), .path_closed(sw_path_closed),
    .bypass_closed(sw_bypass_closed)
  );
endmodule

// File: rtl/sup_backup_chk.sv
module sup_backup_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] vmain_code,
  input logic [CW-1:0] vbak_code,
  input logic [CW-1:0] vref_code,
  input logic          on_backup,
  input logic          sw_key_closed,
  input logic          sw_path_closed,
  input logic          sw_bypass_closed
);
  logic [CW-1:0] lim;
  assign lim = (vref_code <= vbak_code) ? vref_code : vbak_code;

  assert_enter_R1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vmain_code < lim) |=> on_backup);

  assert_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vmain_code >= lim) |=> !on_backup);

  assert_open_on_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_backup) |-> (!sw_key_closed && !sw_path_closed && !sw_bypass_closed));

  assert_bypass_needs_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_bypass_closed |-> (sw_key_closed && sw_path_closed));

  assert_backup_stays_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    on_backup |=> (!sw_key_closed && !sw_path_closed && !sw_bypass_closed));
endmodule

bind sup_backup_ctl sup_backup_chk #(.CW(CW)) u_sup_backup_chk (
  .clk(clk), .rst_n(rst_n), .vmain_code(vmain_code), .vbak_code(vbak_code),
  .vref_code(vref_code), .on_backup(on_backup), .sw_key_closed(sw_key_closed),
  .sw_path_closed(sw_path_closed), .sw_bypass_closed(sw_bypass_closed)
);

// File: tb/test_sup_backup_ctl.sv
module test_sup_backup_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] vmain_code = 8'd165, vbak_code = 8'd160, vref_code = 8'd140;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00, wr_data = 8'h00;
  logic       on_backup, sw_key_closed, sw_path_closed, sw_bypass_closed;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int applied = 0;
  int miscompares = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sup_backup_ctl i_sup_backup_ctl (
    .clk(clk), .rst_n(rst_n), .vmain_code(vmain_code), .vbak_code(vbak_code),
    .vref_code(vref_code), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .on_backup(on_backup), .sw_key_closed(sw_key_closed),
    .sw_path_closed(sw_path_closed), .sw_bypass_closed(sw_bypass_closed)
  );

  // exp = {on_backup, key, path, bypass}, state after the next rising edge
  task automatic step(input logic [7:0] vm, input logic [7:0] vb, input logic w,
                      input logic [7:0] a, input logic [7:0] d,
                      input logic [3:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    vmain_code = vm; vbak_code = vb; wr_en = w; wr_addr = a; wr_data = d;
    it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      logic [3:0] act;
      it  = q.pop_front();
      act = {on_backup, sw_key_closed, sw_path_closed, sw_bypass_closed};
      applied++;
      if (act !== it.exp) begin
        miscompares++;
        $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    step(8'd165, 8'd160, 1'b1, 8'h09, 8'h45, 4'b0000, "R9 reset holds");
    step(8'd165, 8'd160, 1'b0, 8'h00, 8'h00, 4'b0000, "R9 reset holds");
    @(negedge clk); rst_n = 1'b1;
    step(8'd165, 8'd160, 1'b0, 8'h00, 8'h00, 4'b0000, "R9 defaults");
    step(8'd165, 8'd160, 1'b1, 8'h09, 8'h45, 4'b0100, "R4 key 5h, R6 bypass waits");
    step(8'd165, 8'd160, 1'b1, 8'h08, 8'h20, 4'b0111, "R5 path bit, R6 bypass");
    step(8'd165, 8'd160, 1'b1, 8'h09, 8'h05, 4'b0110, "R6 bypass bit clear");
    step(8'd165, 8'd160, 1'b1, 8'h09, 8'h06, 4'b0010, "R4 wrong key");
    step(8'd165, 8'd160, 1'b1, 8'h09, 8'h45, 4'b0111, "R4 key restored");
    step(8'd165, 8'd160, 1'b1, 8'h0A, 8'hFF, 4'b0111, "R10 other address");
    step(8'd165, 8'd160, 1'b1, 8'h08, 8'hDF, 4'b0100, "R5 only bit 5 counts");
    step(8'd165, 8'd160, 1'b1, 8'h08, 8'h20, 4'b0111, "R5 path back on");
    step(8'd140, 8'd160, 1'b0, 8'h00, 8'h00, 4'b0111, "R1 equal to reference");
    step(8'd139, 8'd160, 1'b0, 8'h00, 8'h00, 4'b1000, "R1 R7 below reference");
    step(8'd139, 8'd160, 1'b1, 8'h09, 8'h45, 4'b1000, "R8 write on backup");
    step(8'd139, 8'd160, 1'b1, 8'h08, 8'h20, 4'b1000, "R8 write on backup");
    step(8'd150, 8'd160, 1'b0, 8'h00, 8'h00, 4'b0000, "R3 R7 R8 back on main, fields cleared");
    step(8'd150, 8'd160, 1'b1, 8'h09, 8'h45, 4'b0100, "R7 rewrite key");
    step(8'd150, 8'd160, 1'b1, 8'h08, 8'h20, 4'b0111, "R7 rewrite path");
    step(8'd125, 8'd120, 1'b0, 8'h00, 8'h00, 4'b0111, "R2 below ref, above backup");
    step(8'd120, 8'd120, 1'b0, 8'h00, 8'h00, 4'b0111, "R2 equal to backup");
    step(8'd119, 8'd120, 1'b0, 8'h00, 8'h00, 4'b1000, "R2 below backup");
    step(8'd120, 8'd120, 1'b0, 8'h00, 8'h00, 4'b0000, "R3 return at threshold");
    step(8'd150, 8'd160, 1'b1, 8'h09, 8'h45, 4'b0100, "R4 reprogram");
    step(8'd150, 8'd160, 1'b1, 8'h08, 8'h20, 4'b0111, "R5 reprogram");
    step(8'd100, 8'd160, 1'b1, 8'h09, 8'h45, 4'b1000, "R7 write on entry edge");
    step(8'd150, 8'd160, 1'b0, 8'h00, 8'h00, 4'b0000, "R7 entry write discarded");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule